// File: doc/BRIEF.md
# Packed Lane-Split Adder

The block adds or subtracts two 64-bit words that are read as vectors of equal-width elements. A 3-bit operation code picks the element width and chooses between addition and subtraction. Every element of the word is processed in the same cycle. The element width is set by the operation code alone: no length setting exists, and elements always sit next to each other.

A single ripple of 8-bit segment adders does all of the work. Between two segments, the carry is either passed on to the next segment or cut off. The choice depends on the selected width, so no carry can leave one element and enter the next. Each element wraps modulo its own width, and the carry out of its top bit is dropped.

The input and output are valid/ready streams. A beat is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is held in an output register, which raises `out_valid` on that same edge. `in_ready` is high whenever the output register is empty or is being drained in the current cycle. While `out_valid` is high and `out_ready` is low, the output holds its value and no new beat is taken. The producer must keep its beat steady until the beat is accepted.

Top module: `simd_pack_add`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: Operation code bits [1:0] select the element width: 00 gives eight 8-bit elements, 01 gives four 16-bit elements, 10 gives two 32-bit elements, and 11 gives one 64-bit element. Element i occupies bits [i*W+W-1 : i*W], with element 0 in the least significant bits.
- R3: With bit 2 of the operation code at 0, each element of the result equals (a + b) mod 2^W for the matching elements of a and b.
- R4: With bit 2 of the operation code at 1, each element of the result equals (a - b) mod 2^W for the matching elements of a and b.
- R5: No carry or borrow crosses an element boundary. An element that overflows or underflows leaves its neighbours untouched.
- R6: In 64-bit mode, the carry propagates through all 64 bits.
- R7: A beat accepted on one rising edge appears at `out_valid`/`out_sum` immediately after that edge. Beats accepted on consecutive edges come out on consecutive cycles.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_sum` stays stable. The pending result is delivered once `out_ready` rises.
- R9: `out_valid` rises only after a beat has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_op | input | 3 | [1:0] element width, [2] subtract |
| in_a | input | 64 | First operand vector |
| in_b | input | 64 | Second operand vector |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_sum | output | 64 | Packed result vector |

## Verification
A wrong carry-cut map appears directly in `out_sum` on the cycle after acceptance. It shows up as a stray +1 or -1 in the element above a boundary, so overflow and underflow patterns at every width are the probes that expose it. A fault in the output handshake also shows in that first cycle: a result is lost or overwritten while the consumer stalls, or `out_valid` fails to rise after an accepted beat.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int DATA_W = 64;
  localparam int SEG_W  = 8;
  localparam int NSEG   = DATA_W / SEG_W;
  localparam int SZ_W   = 2;

  typedef enum logic [SZ_W-1:0] {
    ESZ_8  = 2'b00,
    ESZ_16 = 2'b01,
    ESZ_32 = 2'b10,
    ESZ_64 = 2'b11
  } elem_sz_e;

  typedef struct packed {
    logic     sub;
    elem_sz_e sz;
  } pk_op_t;
endpackage

// File: rtl/simd_cut_map.sv
module simd_cut_map #(
  parameter int NSEG = 8,
  parameter int SZ_W = 2
) (
  input  logic [SZ_W-1:0] size,
  output logic [NSEG-1:0] cut
);
  logic [31:0] span;

  always_comb begin
    span = (32'd1 << size) - 32'd1;
  end

  for (genvar g = 0; g < NSEG; g++) begin : g_cut
    assign cut[g] = ((32'(g) & span) == 32'd0);
  end
endmodule

// File: rtl/simd_seg_add.sv
module simd_seg_add #(
  parameter int SEG_W = 8
) (
  input  logic [SEG_W-1:0] a,
  input  logic [SEG_W-1:0] b,
  input  logic             invert_b,
  input  logic             cin,
  output logic [SEG_W-1:0] sum,
  output logic             cout
);
  logic [SEG_W-1:0] b_eff;
  logic [SEG_W:0]   full;

  always_comb begin
    b_eff = invert_b ? ~b : b;
    full  = {1'b0, a} + {1'b0, b_eff} + {{SEG_W{1'b0}}, cin};
  end

  assign sum  = full[SEG_W-1:0];
  assign cout = full[SEG_W];
endmodule

// File: rtl/simd_pack_add.sv
module simd_pack_add
  import simd_pkg::*;
#(
  parameter int P_DATA_W = DATA_W,
  parameter int P_SEG_W  = SEG_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SZ_W:0]       in_op,
  input  logic [P_DATA_W-1:0] in_a,
  input  logic [P_DATA_W-1:0] in_b,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [P_DATA_W-1:0] out_sum
);
  localparam int LNSEG = P_DATA_W / P_SEG_W;

  pk_op_t            op;
  logic [LNSEG-1:0]  cut;
  logic [LNSEG-1:0]  cin;
  logic [LNSEG-1:0]  cout;
  logic [P_DATA_W-1:0] sum_c;
  logic              accept;

  assign op = pk_op_t'(in_op);

  simd_cut_map #(.NSEG(LNSEG), .SZ_W(SZ_W)) u_cut (
    .size (op.sz),
    .cut  (cut)
  );

  for (genvar j = 0; j < LNSEG; j++) begin : g_seg
    if (j == 0) begin : g_first
      assign cin[j] = op.sub;
    end else begin : g_rest
      assign cin[j] = cut[j] ? op.sub : cout[j-1];
    end

    simd_seg_add #(.SEG_W(P_SEG_W)) u_seg (
      .a        (in_a[j*P_SEG_W +: P_SEG_W]),
      .b        (in_b[j*P_SEG_W +: P_SEG_W]),
      .invert_b (op.sub),
      .cin      (cin[j]),
      .sum      (sum_c[j*P_SEG_W +: P_SEG_W]),
      .cout     (cout[j])
    );
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (accept) out_sum <= sum_c;
    end
  end
endmodule

// File: rtl/simd_pack_add_chk.sv
module simd_pack_add_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_sum
);
  // R7
  accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum)));

  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9
  valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !$past(rst_n) |-> !out_valid);
endmodule

bind simd_pack_add simd_pack_add_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sum   (out_sum)
);

// File: tb/simd_pack_add_bench.sv
module simd_pack_add_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [2:0]  in_op;
  logic [63:0] in_a;
  logic [63:0] in_b;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] out_sum;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  simd_pack_add u_simd_pack_add (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_sum(out_sum)
  );

  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b, logic [2:0] op);
    int w = 8 << op[1:0];
    logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    logic [63:0] res = '0;
    for (int e = 0; e < 64 / w; e++) begin
      logic [63:0] ea = (a >> (e * w)) & mask;
      logic [63:0] eb = (b >> (e * w)) & mask;
      logic [63:0] r  = op[2] ? ((ea - eb) & mask) : ((ea + eb) & mask);
      res = res | (r << (e * w));
    end
    return res;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic one_beat(string req, logic [2:0] op, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, 64'(out_valid), 64'd1);
    check(req, out_sum, model(a, b, op));
  endtask

  task automatic t_reset;
    check("R1 out_valid", 64'(out_valid), 64'd0);
    check("R1 in_ready", 64'(in_ready), 64'd1);
  endtask

  task automatic t_widths;
    one_beat("R2 R3 byte add", 3'b000, 64'h0102_0304_0506_0708, 64'h1010_2020_3030_4040);
    one_beat("R2 R3 half add", 3'b001, 64'h1234_8000_FFFF_0001, 64'h0001_8000_0001_7FFF);
    one_beat("R2 R3 word add", 3'b010, 64'h8000_0000_FFFF_FFFF, 64'h8000_0000_0000_0002);
    check("R5 word wrap", out_sum, 64'h0000_0000_0000_0001);
    one_beat("R6 quad add", 3'b011, 64'h0000_0000_FFFF_FFFF, 64'h1);
    check("R6 quad carry", out_sum, 64'h0000_0001_0000_0000);
  endtask

  task automatic t_isolation;
    one_beat("R5 byte ovf", 3'b000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101);
    check("R5 byte zero", out_sum, 64'h0);
    one_beat("R5 half ovf", 3'b001, 64'h00FF_FFFF_00FF_FFFF, 64'h0001_0001_0001_0001);
    check("R5 half iso", out_sum, 64'h0100_0000_0100_0000);
  endtask

  task automatic t_subtract;
    one_beat("R4 byte sub", 3'b100, 64'h0, 64'h0101_0101_0101_0101);
    check("R4 byte borrow", out_sum, 64'hFFFF_FFFF_FFFF_FFFF);
    one_beat("R4 half sub", 3'b101, 64'h0005_0000_1234_8000, 64'h0003_0001_0234_0001);
    one_beat("R4 word sub", 3'b110, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001);
    check("R4 word borrow", out_sum, 64'hFFFF_FFFF_FFFF_FFFF);
    one_beat("R4 R6 quad sub", 3'b111, 64'h0000_0001_0000_0000, 64'h1);
    check("R6 quad borrow", out_sum, 64'h0000_0000_FFFF_FFFF);
  endtask

  task automatic t_stream;
    logic [63:0] a1 = 64'h1111_2222_3333_4444, b1 = 64'h0F0F_0F0F_0F0F_0F0F;
    logic [63:0] a2 = 64'hAAAA_5555_AAAA_5555, b2 = 64'h5555_AAAA_5555_AAAB;
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1; in_op = 3'b000; in_a = a1; in_b = b1;
    @(negedge clk);
    check("R7 first valid", 64'(out_valid), 64'd1);
    check("R7 first data", out_sum, model(a1, b1, 3'b000));
    in_op = 3'b011; in_a = a2; in_b = b2;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 second data", out_sum, model(a2, b2, 3'b011));
    @(negedge clk);
    check("R9 idle", 64'(out_valid), 64'd0);
  endtask

  task automatic t_backpressure;
    logic [63:0] a1 = 64'h0102_0304_0506_0708, b1 = 64'h0101_0101_0101_0101;
    logic [63:0] a2 = 64'hFFFF_0000_FFFF_0000, b2 = 64'h0001_0001_0001_0001;
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_op = 3'b000; in_a = a1; in_b = b1;
    @(negedge clk);
    in_op = 3'b001; in_a = a2; in_b = b2;
    check("R8 ready low", 64'(in_ready), 64'd0);
    @(negedge clk);
    @(negedge clk);
    check("R8 held valid", 64'(out_valid), 64'd1);
    check("R8 held data", out_sum, model(a1, b1, 3'b000));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 next data", out_sum, model(a2, b2, 3'b001));
    @(negedge clk);
    check("R8 drained", 64'(out_valid), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_a = '0; in_b = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_widths();
    t_isolation();
    t_subtract();
    t_stream();
    t_backpressure();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule